// File: doc/BRIEF.md
# Board Interrupt Aggregator Register File

This block collects sixteen active-high external interrupt lines from board peripherals and presents one parent interrupt to the processor side. The network controller, for example, is wired to line 3. Each input passes through a two-flop synchroniser. A level vector follows the synchronised value, and a line whose level changes while it is enabled becomes the current event. On an event the status register is overwritten with a one-hot code for that line, and the parent output takes the line's new level. Lines 8 and 12 can never be enabled, because every value written to the enable or status register passes through the filter 0x000FEEFF.

Software reaches the block through a plain synchronous register port inside a 1 MiB byte-addressed window. The enable and status registers sit at fixed offsets. Ten general control words (lamp data, lamp control, switch word, three control words, one read-back word and two card-slot words) store any 32-bit value and return it unchanged. An access to any other offset returns zero and leaves all state as it was, and the error flag is raised for one cycle.

Top module: `board_irq_regfile`

## Requirements
- R1: After reset, every register, the level vector, the parent output, the read data and the error flag are all zero.
- R2: The general words at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each store the full 32-bit write value, and a read returns that value.
- R3: A write to the enable register at offset 0xC0 stores the write value ANDed with 0x000FEEFF. As a result, changes on lines 8 and 12 never raise an event.
- R4: A write to the status register at offset 0xD0 stores the write value ANDed with 0x000FEEFF.
- R5: Read data is registered. It shows the addressed value after the clock edge that samples the read strobe, and it holds that value until the next read.
- R6: A read from any other offset (including unaligned addresses) returns zero. A write to such an offset changes nothing. Either access sets the error flag for the cycle after the access.
- R7: An input level that is stable before clock edge n appears on the level output after edge n+2.
- R8: When an enabled line changes level, the status register becomes a one-hot value with only that line's bit set (bit i for line i). The parent output takes the line's new level, with the same latency as R7.
- R9: A change on a line whose enable bit is clear updates only the level vector. The status register and the parent output are unchanged.
- R10: When several enabled lines change in the same cycle, the lowest-numbered line defines the status value and the parent level.
- R11: If an event lands in the same cycle as a software write to the status register, the event value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | External interrupt lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset inside the window |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| err | output | 1 | One-cycle flag for an access to an undefined offset |
| irq_out | output | 1 | Parent interrupt |
| level_o | output | NUM_LINES | Synchronised level vector |

## Verification
The bench builds the block with its default parameters: sixteen lines, 32-bit data and a 20-bit address. This brings the two filtered lines (8 and 12), every defined offset and nearby unaligned offsets into reach. A behavioural model with its own delay stages is compared against all outputs on every cycle. Directed sequences cover masked toggles, simultaneous enabled changes and an event that collides with a software write to the status register.

// File: rtl/bir_pkg.sv
package bir_pkg;

    localparam int unsigned LINES_DEF  = 16;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned ADDR_W_DEF = 20;
    localparam int unsigned GP_COUNT   = 10;

    // Lines whose bit is clear here can never be enabled or flagged.
    localparam logic [31:0] LINE_FILTER = 32'h000F_EEFF;

    // General words take indexes 0..GP_COUNT-1 so the index feeds the bank directly.
    typedef enum logic [3:0] {
        SEL_LAMP_A   = 4'd0,
        SEL_LAMP_B   = 4'd1,
        SEL_LAMP_CTL = 4'd2,
        SEL_SWITCH   = 4'd3,
        SEL_CTL_A    = 4'd4,
        SEL_CTL_B    = 4'd5,
        SEL_CTL_C    = 4'd6,
        SEL_CTL_RD   = 4'd7,
        SEL_SLOT_A   = 4'd8,
        SEL_SLOT_B   = 4'd9,
        SEL_IRQ_EN   = 4'd10,
        SEL_IRQ_STAT = 4'd11,
        SEL_NONE     = 4'd12
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            32'h10:  return SEL_LAMP_A;
            32'h14:  return SEL_LAMP_B;
            32'h40:  return SEL_LAMP_CTL;
            32'h60:  return SEL_SWITCH;
            32'h80:  return SEL_CTL_A;
            32'h84:  return SEL_CTL_B;
            32'h88:  return SEL_CTL_C;
            32'h90:  return SEL_CTL_RD;
            32'hC0:  return SEL_IRQ_EN;
            32'hD0:  return SEL_IRQ_STAT;
            32'hE0:  return SEL_SLOT_A;
            32'hE4:  return SEL_SLOT_B;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bir_sync.sv
module bir_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/bir_event.sv
module bir_event
    import bir_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] level_o,
    output logic         hit_o,
    output logic [W-1:0] onehot_o,
    output logic         hit_level_o
);
    logic [W-1:0] level_d, level_q;
    logic [W-1:0] armed;

    always_comb begin
        level_d     = sync_i;
        armed       = (sync_i ^ level_q) & mask_i;
        hit_o       = |armed;
        onehot_o    = '0;
        hit_level_o = 1'b0;
        // Scan downward so the lowest armed line is the one that remains.
        for (int i = W - 1; i >= 0; i--) begin
            if (armed[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                hit_level_o = sync_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level_o = level_q;

    // R3
    filtered_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((onehot_o & W'(LINE_FILTER)) != '0));

endmodule

// File: rtl/bir_gpregs.sv
module bir_gpregs #(
    parameter int unsigned N  = 10,
    parameter int unsigned DW = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] regs_d [N];
    logic [DW-1:0] regs_q [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        assign regs_d[g] = (wr_en && wr_idx == IW'(g)) ? wr_data : regs_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) rd_val = regs_q[i];
        end
    end

endmodule

// File: rtl/board_irq_regfile.sv
module board_irq_regfile
    import bir_pkg::*;
#(
    parameter int unsigned NUM_LINES = LINES_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter int unsigned ADDR_W    = ADDR_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 err,
    output logic                 irq_out,
    output logic [NUM_LINES-1:0] level_o
);
    localparam int unsigned      IW     = $clog2(GP_COUNT);
    localparam logic [DATA_W-1:0] FILTER = DATA_W'(LINE_FILTER);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] stat;
        logic              parent;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] sync_lines;
    logic                 hit;
    logic [NUM_LINES-1:0] hit_onehot;
    logic                 hit_level;
    reg_sel_e             sel;
    logic                 gp_wr;
    logic [IW-1:0]        gp_idx;
    logic [DATA_W-1:0]    gp_val;
    logic [DATA_W-1:0]    rd_mux;

    bir_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_lines)
    );

    bir_event #(.W(NUM_LINES)) u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_lines),
        .mask_i      (st_q.mask[NUM_LINES-1:0]),
        .level_o     (level_o),
        .hit_o       (hit),
        .onehot_o    (hit_onehot),
        .hit_level_o (hit_level)
    );

    assign sel    = decode_offset(32'(addr));
    assign gp_idx = IW'(sel);
    assign gp_wr  = wr_en && (sel < SEL_IRQ_EN);

    bir_gpregs #(.N(GP_COUNT), .DW(DATA_W)) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gp_wr),
        .wr_idx  (gp_idx),
        .wr_data (wr_data),
        .rd_idx  (gp_idx),
        .rd_val  (gp_val)
    );

    always_comb begin
        case (sel)
            SEL_IRQ_EN:   rd_mux = st_q.mask;
            SEL_IRQ_STAT: rd_mux = st_q.stat;
            SEL_NONE:     rd_mux = '0;
            default:      rd_mux = gp_val;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = (rd_en || wr_en) && (sel == SEL_NONE);
        if (rd_en) st_d.rdata = rd_mux;
        if (wr_en && sel == SEL_IRQ_EN)   st_d.mask = wr_data & FILTER;
        if (wr_en && sel == SEL_IRQ_STAT) st_d.stat = wr_data & FILTER;
        // A line event takes precedence over a software status write.
        if (hit) begin
            st_d.stat   = DATA_W'(hit_onehot);
            st_d.parent = hit_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign err     = st_q.err;
    assign irq_out = st_q.parent;

    // R6
    err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(rd_en || wr_en));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

    // R9
    parent_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_out) |-> $past(hit));

    // R8
    stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |-> ($countones(st_q.stat) == 1));

endmodule

// File: tb/tb_board_irq_regfile.sv
module tb_board_irq_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        err;
    logic        irq_out;
    logic [15:0] level;

    always #5 clk = ~clk;

    board_irq_regfile dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wdata),
        .rd_data (rd_data),
        .err     (err),
        .irq_out (irq_out),
        .level_o (level)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // ---------------- behavioural reference ----------------
    logic [15:0] m_s1, m_s2, m_lvl;
    logic [31:0] m_reg [12];
    logic [31:0] m_rd;
    logic        m_err, m_par;
    logic [15:0] m_en;
    logic        m_hit, m_np;
    logic [31:0] m_ns;
    int          m_slot;

    function automatic int slot_of(input logic [19:0] a);
        case (a)
            20'h10: return 0;  20'h14: return 1;  20'h40: return 2;
            20'h60: return 3;  20'h80: return 4;  20'h84: return 5;
            20'h88: return 6;  20'h90: return 7;  20'hE0: return 8;
            20'hE4: return 9;  20'hC0: return 10; 20'hD0: return 11;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_rd = '0; m_err = 1'b0; m_par = 1'b0;
            for (int i = 0; i < 12; i++) m_reg[i] = '0;
        end else begin
            m_en  = (m_s2 ^ m_lvl) & m_reg[10][15:0];
            m_hit = 1'b0; m_ns = '0; m_np = m_par;
            for (int i = 0; i < 16; i++) begin
                if (m_en[i] && !m_hit) begin
                    m_hit = 1'b1; m_ns = 32'd1 << i; m_np = m_s2[i];
                end
            end
            m_slot = slot_of(addr);
            m_err  = (rd_en || wr_en) && (m_slot < 0);
            if (rd_en) m_rd = (m_slot < 0) ? 32'h0 : m_reg[m_slot];
            if (wr_en && m_slot >= 0)
                m_reg[m_slot] = (m_slot >= 10) ? (wdata & 32'h000F_EEFF) : wdata;
            if (m_hit) begin m_reg[11] = m_ns; m_par = m_np; end
            m_lvl = m_s2; m_s2 = m_s1; m_s1 = irq;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R7 level vs model", {16'h0, level}, {16'h0, m_lvl});
        chk("R8 parent vs model", {31'h0, irq_out}, {31'h0, m_par});
        chk("R6 err vs model", {31'h0, err}, {31'h0, m_err});
        chk("R5 rd_data vs model", rd_data, m_rd);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) cmp_all();
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [19:0] a, input logic [31:0] exp);
        addr = a; rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk(tag, rd_data, exp);
    endtask

    logic [19:0] gp_off [10] = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80,
                                 20'h84, 20'h88, 20'h90, 20'hE0, 20'hE4};

    initial begin
        cycn(3);
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1 parent", {31'h0, irq_out}, 32'h0);
        chk("R1 level", {16'h0, level}, 32'h0);
        chk("R1 err", {31'h0, err}, 32'h0);
        rdchk("R1 enable reg", 20'hC0, 32'h0);
        rdchk("R1 status reg", 20'hD0, 32'h0);
        rdchk("R1 lamp word", 20'h10, 32'h0);

        // R2: general words
        for (int i = 0; i < 10; i++) wr(gp_off[i], 32'hC3A5_0000 ^ (32'h0101_1111 * (i + 1)));
        for (int i = 0; i < 10; i++) rdchk("R2 general word", gp_off[i], 32'hC3A5_0000 ^ (32'h0101_1111 * (i + 1)));

        // R4: status write filter
        wr(20'hD0, 32'hFFFF_FFFF);
        rdchk("R4 status filter", 20'hD0, 32'h000F_EEFF);
        wr(20'hD0, 32'h0);

        // R3: enable write filter
        wr(20'hC0, 32'hFFFF_FFFF);
        rdchk("R3 enable filter", 20'hC0, 32'h000F_EEFF);

        // R6: undefined offsets
        wr(20'h44, 32'hDEAD_BEEF);
        chk("R6 err on bad write", {31'h0, err}, 32'h1);
        wr(20'h11, 32'h1234_5678);
        rdchk("R6 unaligned write ignored", 20'h10, 32'hC3A5_0000 ^ 32'h0101_1111);
        rdchk("R6 bad read zero", 20'h12, 32'h0);
        chk("R6 err on bad read", {31'h0, err}, 32'h1);
        cyc();
        chk("R6 err one cycle", {31'h0, err}, 32'h0);

        // R5: read data held
        rdchk("R5 read", 20'h14, 32'hC3A5_0000 ^ (32'h0101_1111 * 2));
        cycn(2);
        chk("R5 hold", rd_data, 32'hC3A5_0000 ^ (32'h0101_1111 * 2));

        // R7/R8: enabled line 3
        wr(20'hC0, 32'h0000_0008);
        irq = 16'h0008;
        cyc(); cyc();
        chk("R7 not yet", {16'h0, level}, 32'h0);
        cyc();
        chk("R7 level latency", {16'h0, level}, 32'h0008);
        chk("R8 parent rises", {31'h0, irq_out}, 32'h1);
        rdchk("R8 status one-hot", 20'hD0, 32'h0000_0008);
        irq = 16'h0000;
        cycn(3);
        chk("R8 parent falls", {31'h0, irq_out}, 32'h0);
        rdchk("R8 status after fall", 20'hD0, 32'h0000_0008);

        // R9: masked line 5
        irq = 16'h0020;
        cycn(3);
        chk("R9 level updates", {16'h0, level}, 32'h0020);
        chk("R9 parent unchanged", {31'h0, irq_out}, 32'h0);
        rdchk("R9 status unchanged", 20'hD0, 32'h0000_0008);

        // R3: lines 8 and 12 can never fire
        wr(20'hC0, 32'hFFFF_FFFF);
        irq = 16'h1120;
        cycn(3);
        chk("R3 level of filtered lines", {16'h0, level}, 32'h1120);
        chk("R3 filtered lines no parent", {31'h0, irq_out}, 32'h0);
        rdchk("R3 filtered lines no status", 20'hD0, 32'h0000_0008);

        // R10: lines 6 and 9 together
        irq = 16'h1360;
        cycn(3);
        chk("R10 parent", {31'h0, irq_out}, 32'h1);
        rdchk("R10 lowest line wins", 20'hD0, 32'h0000_0040);

        // R11: event collides with status write
        irq = 16'h1320;
        cyc(); cyc();
        wr(20'hD0, 32'h0000_0000);
        chk("R11 parent from event", {31'h0, irq_out}, 32'h0);
        rdchk("R11 event beats write", 20'hD0, 32'h0000_0040);

        cycn(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: all requirements, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule